// File: doc/BRIEF.md
# Single-Accumulator 16-bit Processor Core

This core runs a small program held in a word-addressed memory of 16-bit words through one address port, one read-data port and one write-data port with a write strobe. Each instruction word holds an operation code in its upper four bits and a 12-bit direct operand address in its lower twelve bits. That gives a 4K-word space. The core keeps a program counter, an accumulator and a latched copy of the instruction whose arithmetic result is still on its way.

The core alternates between a fetch cycle and an execute cycle. The memory reads synchronously with one cycle of latency, so an operand requested in an execute cycle arrives during the next fetch cycle. It is combined into the accumulator at the end of that fetch cycle, which overlaps with the next instruction's fetch. Conditional jumps test whether the accumulator is zero or negative. A stop instruction freezes the core and raises a halted output until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the core drives address 0 with the write strobe low and halted low. Program counter and accumulator both start at 0.
- R2: Bits [15:12] of an instruction select the operation and bits [11:0] give the operand address S. Codes: 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 jump if not negative, 6 jump if not zero, 7 stop.
- R3: Load sets ACC to mem[S]. Add sets ACC to ACC+mem[S] and subtract sets ACC to ACC-mem[S], both wrapping modulo 2^16. The new value is visible to the very next instruction.
- R4: A store raises the write strobe for exactly its execute cycle, with the address set to S and the write data set to ACC.
- R5: Code 4 always continues execution at S.
- R6: Code 5 jumps to S only when ACC bit 15 is 0. Code 6 jumps to S only when ACC is not 0. Otherwise execution continues at the next address.
- R7: Code 7 and codes 8 to 15 stop the core. Halted rises after the stop instruction's execute cycle and stays high until reset. While halted, no write occurs and the address stays unchanged.
- R8: Every instruction takes exactly two clock cycles. A program of N instructions executed, the stop included, raises halted after 2N rising edges following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address to memory |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_we | output | 1 | Write strobe |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
A store is due in the execute cycle, which is the odd cycle of its instruction pair. The monitor samples the write port at each falling edge and checks every strobe against the next entry that an instruction-level model has queued, so a store that arrives early, late or extra is caught. Halted is due after exactly 2N rising edges, and the bench counts edges from reset release to compare against N from the model. After halt, the hold is sampled on each falling edge over many cycles.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned OPW = 4;
  localparam logic [OPW-1:0] OP_LOAD  = 4'd0;
  localparam logic [OPW-1:0] OP_STORE = 4'd1;
  localparam logic [OPW-1:0] OP_ADD   = 4'd2;
  localparam logic [OPW-1:0] OP_SUB   = 4'd3;
  localparam logic [OPW-1:0] OP_JMP   = 4'd4;
  localparam logic [OPW-1:0] OP_JGE   = 4'd5;
  localparam logic [OPW-1:0] OP_JNZ   = 4'd6;
  localparam logic [OPW-1:0] OP_STOP  = 4'd7;

  // kind of accumulator update still pending from the last execute cycle
  typedef enum logic [1:0] {
    K_LOAD = 2'd0,
    K_NONE = 2'd1,
    K_ADD  = 2'd2,
    K_SUB  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int unsigned DW = 16
) (
  input  acc_pkg::acc_kind_e kind,
  input  logic [DW-1:0]      acc_in,
  input  logic [DW-1:0]      opnd,
  output logic [DW-1:0]      result
);
  import acc_pkg::*;

  function automatic logic [DW-1:0] combine(input acc_kind_e k,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    case (k)
      K_LOAD:  return b;
      K_ADD:   return a + b;
      K_SUB:   return a - b;
      default: return a;
    endcase
  endfunction

  assign result = combine(kind, acc_in, opnd);
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl #(
  parameter int unsigned OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_in,
  input  logic           acc_zero,
  input  logic           acc_neg,
  output logic           fetch_en,
  output logic           exec_en,
  output logic           jump_take,
  output logic           pend_set,
  output logic           sel_opnd,
  output logic           mem_we,
  output logic           halted
);
  import acc_pkg::*;

  logic phase_q;   // 0 fetch, 1 execute
  logic halt_q;
  logic is_stop;
  logic is_memop;

  assign fetch_en = !phase_q && !halt_q;
  assign exec_en  =  phase_q && !halt_q;
  assign halted   = halt_q;

  always_comb begin
    is_stop  = (op_in >= OP_STOP);
    is_memop = (op_in <= OP_SUB);
    jump_take = 1'b0;
    if (exec_en) begin
      case (op_in)
        OP_JMP:  jump_take = 1'b1;
        OP_JGE:  jump_take = !acc_neg;
        OP_JNZ:  jump_take = !acc_zero;
        default: jump_take = 1'b0;
      endcase
    end
    mem_we   = exec_en && (op_in == OP_STORE);
    sel_opnd = exec_en && is_memop;
    pend_set = exec_en && is_memop && (op_in != OP_STORE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      halt_q  <= 1'b0;
    end else if (!halt_q) begin
      phase_q <= !phase_q;
      if (exec_en && is_stop) halt_q <= 1'b1;
    end
  end

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r7_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
  a_r8_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> exec_en);
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath #(
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 12,
  parameter int unsigned OPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic          exec_en,
  input  logic          jump_take,
  input  logic          pend_set,
  input  logic          sel_opnd,
  input  logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          acc_zero,
  output logic          acc_neg
);
  import acc_pkg::*;

  localparam logic [AW-1:0] PC_STEP = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q;
  acc_kind_e     pend_q;
  logic [DW-1:0] alu_y;
  logic [AW-1:0] opnd_addr;
  logic [OPW-1:0] op_bits;

  assign opnd_addr = mem_rdata[AW-1:0];
  assign op_bits   = mem_rdata[DW-1 -: OPW];

  acc_alu #(.DW(DW)) u_alu (
    .kind   (pend_q),
    .acc_in (acc_q),
    .opnd   (mem_rdata),
    .result (alu_y)
  );

  assign mem_addr  = sel_opnd ? opnd_addr : pc_q;
  assign mem_wdata = acc_q;
  assign acc_zero  = (acc_q == '0);
  assign acc_neg   = acc_q[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      acc_q  <= '0;
      pend_q <= K_NONE;
    end else if (fetch_en) begin
      pc_q   <= pc_q + PC_STEP;
      acc_q  <= alu_y;
      pend_q <= K_NONE;
    end else if (exec_en) begin
      if (jump_take) pc_q <= opnd_addr;
      pend_q <= pend_set ? acc_kind_e'(op_bits[1:0]) : K_NONE;
    end
  end

  a_r4_store_target: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == opnd_addr));
  a_r5_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
    jump_take |=> (pc_q == $past(opnd_addr)));
  a_r6_untaken_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !jump_take) |=> $stable(pc_q));
  a_r7_frozen_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !exec_en) |=> ($stable(pc_q) && $stable(acc_q)));
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 12,
  parameter int unsigned OPW = DW - AW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halted
);
  logic fetch_en, exec_en, jump_take, pend_set, sel_opnd;
  logic acc_zero, acc_neg;

  acc_ctrl #(.OPW(OPW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_in     (mem_rdata[DW-1 -: OPW]),
    .acc_zero  (acc_zero),
    .acc_neg   (acc_neg),
    .fetch_en  (fetch_en),
    .exec_en   (exec_en),
    .jump_take (jump_take),
    .pend_set  (pend_set),
    .sel_opnd  (sel_opnd),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  acc_dpath #(.DW(DW), .AW(AW), .OPW(OPW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_en  (fetch_en),
    .exec_en   (exec_en),
    .jump_take (jump_take),
    .pend_set  (pend_set),
    .sel_opnd  (sel_opnd),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc_zero  (acc_zero),
    .acc_neg   (acc_neg)
  );

  a_r1_reset_fetch_zero: assert property (@(posedge clk)
    !rst_n |=> (mem_addr == '0 && !mem_we && !halted));
endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted;

  always #10ns clk = !clk;   // 50 MHz

  acc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
  );

  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  typedef struct { logic [11:0] a; logic [15:0] d; } st_t;
  st_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [3:0] op, input int s);
    mem[a] = {op, 12'(s)};
  endtask

  // instruction-level model from the requirements: pushes expected stores
  task automatic predict(output int n);
    logic [15:0] m [0:255];
    logic [11:0] pc = '0;
    logic [15:0] acc = '0;
    logic [15:0] ins;
    n = 0;
    for (int i = 0; i < 256; i++) m[i] = mem[i];
    for (int k = 0; k < 2000; k++) begin
      ins = m[pc[7:0]];
      n++;
      pc = pc + 12'd1;
      case (ins[15:12])
        4'd0: acc = m[ins[7:0]];
        4'd1: begin m[ins[7:0]] = acc; exp_q.push_back('{ins[11:0], acc}); end
        4'd2: acc = acc + m[ins[7:0]];
        4'd3: acc = acc - m[ins[7:0]];
        4'd4: pc = ins[11:0];
        4'd5: if (acc[15] == 1'b0) pc = ins[11:0];
        4'd6: if (acc != 16'd0) pc = ins[11:0];
        default: break;
      endcase
    end
  endtask

  // scoreboard monitor: every write strobe must match the next expected store
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected store", {20'd0, mem_addr}, 32'd0);
      end else begin
        st_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.a, "R4", "store address", {20'd0, mem_addr}, {20'd0, e.a});
        check(mem_wdata == e.d, "R3 R5 R6", "store data", {16'd0, mem_wdata}, {16'd0, e.d});
      end
    end
  end

  task automatic run_program(input string tag);
    int n_exp, edges;
    logic [11:0] hold_addr;
    predict(n_exp);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(mem_addr == 12'd0 && !mem_we && !halted, "R1", "reset outputs",
          {19'd0, halted, mem_we, mem_addr}, 32'd0);
    rst_n = 1'b1;
    edges = 0;
    while (!halted && edges < 4000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    check(halted, "R7", {tag, " halt reached"}, {31'd0, halted}, 32'd1);
    check(edges == 2 * n_exp, "R8", {tag, " cycles to halt"}, edges, 2 * n_exp);
    hold_addr = mem_addr;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(halted && !mem_we && mem_addr == hold_addr, "R7", {tag, " held after stop"},
            {19'd0, halted, mem_we, mem_addr}, {19'd0, 1'b1, 1'b0, hold_addr});
    end
    check(exp_q.size() == 0, "R4", {tag, " stores outstanding"}, exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // R2 encoding: {op[3:0], S[11:0]}
    mem[100] = 16'd5;  mem[101] = 16'd7;  mem[102] = 16'd20;
    mem[103] = 16'h7FFF; mem[104] = 16'd1; mem[105] = 16'h8000; mem[106] = 16'd3;
    put(0, 4'd0, 100); put(1, 4'd2, 101); put(2, 4'd1, 200);
    put(3, 4'd3, 102); put(4, 4'd1, 201);
    put(5, 4'd5, 8);   put(6, 4'd6, 9);   put(7, 4'd7, 0); put(8, 4'd7, 0);
    put(9, 4'd0, 103); put(10, 4'd2, 104); put(11, 4'd1, 202);
    put(12, 4'd3, 105); put(13, 4'd6, 7); put(14, 4'd5, 16); put(15, 4'd7, 0);
    put(16, 4'd0, 106); put(17, 4'd3, 104); put(18, 4'd1, 106); put(19, 4'd6, 16);
    put(20, 4'd4, 22); put(21, 4'd7, 0);
    put(22, 4'd0, 101); put(23, 4'd1, 203);
    put(24, 4'd9, 0);   // undefined code acts as stop (R7)
    run_program("progA");

    // second run: reset from halt, ACC must be zero again (R1)
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    put(0, 4'd1, 210); put(1, 4'd2, 211); put(2, 4'd1, 212); put(3, 4'd7, 0);
    mem[211] = 16'hFFFF;
    run_program("progB");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule